// File: doc/BRIEF.md
# Edge and Level Interrupt Controller

This block watches sixteen external input lines and one separate non-maskable line. Every line first passes a two-flop synchroniser. An optional glitch filter then takes the majority of the last three synchronised samples. A per-line detector, set by a 3-bit mode, then looks for a rising edge, a falling edge, either edge, a high level or a low level. A hit sets the line's pending flag. The flags, masked by a per-line enable, are ORed into one interrupt request. A separate event mask turns chosen detections into single-cycle event pulses.

The non-maskable line has its own mode, filter and flag. Its flag drives the non-maskable output directly. A bypass bit lets that line skip the filter, which stands in for clock-free detection. Software reaches all state through a simple single-cycle register bus. Writes take effect at the clock edge. Reads return data combinationally from the address.

Top module: `xint_ctrl`

## Requirements
- R1: The mode field detects nothing for 0, a rising edge for 1, a falling edge for 2, either edge for 3, a high level for 4 and a low level for 5. Codes 6 and 7 detect nothing.
- R2: Line n is configured by a 4-bit nibble at bits 4*(n mod 8). It sits in word 8 for lines 0 to 7 and in word 9 for lines 8 to 15. Nibble bits [2:0] are the mode and bit 3 enables the filter.
- R3: Without the filter, a flag is readable three clock edges after its input changes. With the filter it takes four edges, and a pulse lasting one cycle sets no flag. Without the filter, that same pulse does set a flag.
- R4: Writing ones to word 6 enables those lines' interrupts, and writing ones to word 5 disables them. Reading either word returns the current enable mask.
- R5: The pending flags sit in word 7. Writing a one to a bit clears that flag, and writing zero leaves it unchanged. A detection in the same cycle as the clear wins.
- R6: In level modes the flag is set again on every cycle the level holds. It cannot be cleared until the input leaves that level.
- R7: irq_o is high exactly when some line has both its flag and its enable set.
- R8: evt_o pulses for one cycle, in the cycle its flag becomes set, and only for lines whose bit is set in the event mask (word 4).
- R9: The non-maskable line is configured in word 2. Bits [2:0] are the mode, bit 3 is the filter and bit 4 bypasses the filter. Its flag is bit 0 of word 3, cleared by writing one, and nmi_o equals that flag.
- R10: Word 0 bit 1 enables the controller. A write takes effect SYNC_CYC cycles later, and bit 1 of busy word 1 is high meanwhile. While the controller is disabled, no flag is set and no event is produced.
- R11: Writing one to word 0 bit 0 also raises busy bit 0. After SYNC_CYC cycles, every configuration register, enable, mask, flag and the controller enable return to zero.
- R12: Word 10 returns the current filtered level of each of the sixteen lines.
- R13: After reset all registers read zero, and irq_o, nmi_o and evt_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| line_in | input | 16 | External lines |
| nmi_in | input | 1 | Non-maskable line |
| irq_o | output | 1 | Combined interrupt request |
| nmi_o | output | 1 | Non-maskable request |
| evt_o | output | 16 | Single-cycle event pulses |

## Verification
The assertions assume three things. The lines carry no meaningful change shorter than one clock. The control word is not written again while a change is still pending in busy. Each bus access lasts one cycle. The stimulus meets all three. It changes lines only on falling clock edges. After every control write it waits out the busy window. It holds the strobe for one cycle only.

// File: rtl/xint_ctrl.sv
module xint_ctrl #(
  parameter int NLINES   = 16,
  parameter int SYNC_CYC = 2,
  parameter int AW       = 4,
  parameter int DW       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NLINES-1:0] line_in,
  input  logic              nmi_in,
  output logic              irq_o,
  output logic              nmi_o,
  output logic [NLINES-1:0] evt_o
);
  localparam int NCFGW    = NLINES / 8;
  localparam int CW       = $clog2(SYNC_CYC + 1);
  localparam int A_CTRL   = 0;
  localparam int A_BUSY   = 1;
  localparam int A_NCFG   = 2;
  localparam int A_NFLAG  = 3;
  localparam int A_EVM    = 4;
  localparam int A_ENC    = 5;
  localparam int A_ENS    = 6;
  localparam int A_FLAG   = 7;
  localparam int A_CFG0   = 8;
  localparam int A_PIN    = A_CFG0 + NCFGW;

  function automatic logic hit(input logic [2:0] mode, input logic cur, input logic prv);
    case (mode)
      3'd1:    hit = cur & ~prv;
      3'd2:    hit = ~cur & prv;
      3'd3:    hit = cur ^ prv;
      3'd4:    hit = cur;
      3'd5:    hit = ~cur;
      default: hit = 1'b0;
    endcase
  endfunction

  logic [NLINES:0]     s1, s2, s3, s4, lvl_q, filt, maj;
  logic [NLINES-1:0]   flags, en, evm, evt_q, det;
  logic [4*NLINES-1:0] cfg;
  logic [4:0]          ncfg;
  logic                nflag, ndet;
  logic                ctrl_en, pend_en, pend_rst;
  logic [1:0]          busy;
  logic [CW-1:0]       cnt;

  wire wr    = bus_sel & bus_we;
  wire apply = (cnt == CW'(1));
  wire swrst = apply & pend_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; s4 <= '0; lvl_q <= '0;
    end else begin
      s1    <= {nmi_in, line_in};
      s2    <= s1;
      s3    <= s2;
      s4    <= s3;
      lvl_q <= filt;
    end
  end

  assign maj = (s2 & s3) | (s2 & s4) | (s3 & s4);

  always_comb begin
    for (int i = 0; i < NLINES; i++) begin
      filt[i] = cfg[4*i+3] ? maj[i] : s2[i];
      det[i]  = ctrl_en & hit(cfg[4*i +: 3], filt[i], lvl_q[i]);
    end
    filt[NLINES] = (ncfg[3] & ~ncfg[4]) ? maj[NLINES] : s2[NLINES];
    ndet = ctrl_en & hit(ncfg[2:0], filt[NLINES], lvl_q[NLINES]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || swrst) begin
      flags <= '0; en <= '0; evm <= '0; evt_q <= '0; cfg <= '0;
      ncfg <= '0; nflag <= 1'b0; ctrl_en <= 1'b0;
      pend_en <= 1'b0; pend_rst <= 1'b0; busy <= '0; cnt <= '0;
    end else begin
      flags <= (flags & ~((wr && bus_addr == AW'(A_FLAG)) ? bus_wdata[NLINES-1:0] : '0)) | det;
      nflag <= (nflag & ~(wr && bus_addr == AW'(A_NFLAG) && bus_wdata[0])) | ndet;
      evt_q <= det & ~flags & evm;
      if (wr && bus_addr == AW'(A_ENS)) en <= en | bus_wdata[NLINES-1:0];
      if (wr && bus_addr == AW'(A_ENC)) en <= en & ~bus_wdata[NLINES-1:0];
      if (wr && bus_addr == AW'(A_EVM)) evm <= bus_wdata[NLINES-1:0];
      if (wr && bus_addr == AW'(A_NCFG)) ncfg <= bus_wdata[4:0];
      for (int w = 0; w < NCFGW; w++)
        if (wr && bus_addr == AW'(A_CFG0 + w)) cfg[32*w +: 32] <= bus_wdata[31:0];
      if (wr && bus_addr == AW'(A_CTRL) && cnt == '0) begin
        pend_en  <= bus_wdata[1];
        pend_rst <= bus_wdata[0];
        busy     <= {1'b1, bus_wdata[0]};
        cnt      <= CW'(SYNC_CYC);
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (apply) begin
          ctrl_en <= pend_en;
          busy    <= '0;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      A_CTRL:       bus_rdata = DW'({ctrl_en, 1'b0});
      A_BUSY:       bus_rdata = DW'(busy);
      A_NCFG:       bus_rdata = DW'(ncfg);
      A_NFLAG:      bus_rdata = DW'(nflag);
      A_EVM:        bus_rdata = DW'(evm);
      A_ENC, A_ENS: bus_rdata = DW'(en);
      A_FLAG:       bus_rdata = DW'(flags);
      A_PIN:        bus_rdata = DW'(filt[NLINES-1:0]);
      default: begin
        for (int w = 0; w < NCFGW; w++)
          if (bus_addr == AW'(A_CFG0 + w)) bus_rdata = DW'(cfg[32*w +: 32]);
      end
    endcase
  end

  assign irq_o = |(flags & en);
  assign nmi_o = nflag;
  assign evt_o = evt_q;
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk #(
  parameter int NLINES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              nmi_o,
  input logic [NLINES-1:0] evt_o,
  input logic [NLINES-1:0] flags,
  input logic              ctrl_en,
  input logic [1:0]        busy
);
  a_r8_evt_marks_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_o) |-> ((evt_o & ~flags) == '0));

  a_r8_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_o) |=> ((evt_o & $past(evt_o)) == '0));

  a_r7_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|flags));

  a_r10_off_no_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> ((flags & ~$past(flags)) == '0));

  a_r9_nmi_off_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !nmi_o) |=> !nmi_o);

  a_r11_busy_pair: assert property (@(posedge clk) disable iff (!rst_n)
    busy[0] |-> busy[1]);
endmodule

bind xint_ctrl xint_ctrl_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .nmi_o(nmi_o), .evt_o(evt_o),
  .flags(flags), .ctrl_en(ctrl_en), .busy(busy)
);

// File: tb/test_xint_ctrl.sv
module test_xint_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] lines = '0;
  logic        nmi = 1'b0;
  logic        irq, nmio;
  logic [15:0] evt;
  int          total = 0, fails = 0;
  logic [31:0] v;

  // {mode[2:0], filter, start, end, expected flag}
  localparam logic [6:0] VEC [16] = '{
    7'b001_0_0_1_1, 7'b001_0_1_0_0, 7'b010_0_1_0_1, 7'b010_0_0_1_0,
    7'b011_0_0_1_1, 7'b011_0_1_0_1, 7'b100_0_0_1_1, 7'b100_0_0_0_0,
    7'b101_0_1_0_1, 7'b101_0_1_1_0, 7'b000_0_0_1_0, 7'b110_0_0_1_0,
    7'b111_0_1_0_0, 7'b001_1_0_1_1, 7'b011_1_1_0_1, 7'b010_1_0_1_0};

  xint_ctrl i_xint_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .line_in(lines), .nmi_in(nmi),
    .irq_o(irq), .nmi_o(nmio), .evt_o(evt));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; sel = 1'b1; we = 1'b0;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R13 reset state
    rd(4'd7, v);  chk("R13 flags", v, 0);
    rd(4'd6, v);  chk("R13 enables", v, 0);
    rd(4'd8, v);  chk("R13 cfg0", v, 0);
    rd(4'd0, v);  chk("R13 ctrl", v, 0);
    chk("R13 outputs", {irq, nmio, evt}, 0);

    // R10 enable with busy window
    wr(4'd0, 32'h2);
    rd(4'd1, v);  chk("R10 busy while syncing", v, 32'h2);
    step(2);
    rd(4'd1, v);  chk("R10 busy done", v, 0);
    rd(4'd0, v);  chk("R10 enabled", v, 32'h2);

    // R1 R2 vector walk, one line per entry
    for (int i = 0; i < 16; i++) begin
      wr(4'd8, 0); wr(4'd9, 0);
      lines = '0; lines[i] = VEC[i][2];
      step(6);
      wr(4'd7, 32'hFFFF);
      wr(4'(8 + i / 8), 32'({VEC[i][3], VEC[i][6:4]}) << (4 * (i % 8)));
      lines[i] = VEC[i][1];
      step(6);
      rd(4'd7, v);
      chk($sformatf("R1 R2 vector %0d", i), 32'(v[i]), 32'(VEC[i][0]));
    end
    wr(4'd8, 0); wr(4'd9, 0); lines = '0; step(6); wr(4'd7, 32'hFFFF);

    // R3 latency, no filter
    wr(4'd8, 32'h1);
    lines[0] = 1'b1; step(2);
    rd(4'd7, v); chk("R3 no flag after two edges", v, 0);
    step(1);
    rd(4'd7, v); chk("R3 flag after three edges", v, 1);
    lines[0] = 1'b0; step(5); wr(4'd7, 32'hFFFF);
    // R3 latency, filter
    wr(4'd8, 32'h9);
    lines[0] = 1'b1; step(3);
    rd(4'd7, v); chk("R3 filtered none after three", v, 0);
    step(1);
    rd(4'd7, v); chk("R3 filtered flag after four", v, 1);
    lines[0] = 1'b0; step(6); wr(4'd7, 32'hFFFF);
    // R3 glitch rejection
    lines[0] = 1'b1; step(1); lines[0] = 1'b0; step(6);
    rd(4'd7, v); chk("R3 glitch rejected", v, 0);
    wr(4'd8, 32'h1);
    lines[0] = 1'b1; step(1); lines[0] = 1'b0; step(6);
    rd(4'd7, v); chk("R3 glitch seen unfiltered", v, 1);

    // R4 enables
    wr(4'd7, 32'hFFFF);
    wr(4'd6, 32'h5);
    rd(4'd6, v); chk("R4 set readback", v, 5);
    rd(4'd5, v); chk("R4 clear-word readback", v, 5);
    wr(4'd5, 32'h1);
    rd(4'd6, v); chk("R4 cleared bit0", v, 4);

    // R7 irq masking
    lines[0] = 1'b1; step(6);
    chk("R7 disabled line gives no irq", 32'(irq), 0);
    wr(4'd8, 32'h101);
    lines[2] = 1'b1; step(6);
    chk("R7 enabled line raises irq", 32'(irq), 1);

    // R5 write-one-to-clear
    wr(4'd7, 32'h0);
    rd(4'd7, v); chk("R5 zero write keeps flags", v, 32'h5);
    wr(4'd7, 32'h4);
    rd(4'd7, v); chk("R5 one clears only its bit", v, 32'h1);
    chk("R7 irq drops", 32'(irq), 0);
    lines = '0; wr(4'd8, 0); step(6); wr(4'd7, 32'hFFFF);

    // R6 level held
    wr(4'd8, 32'h4000);
    lines[3] = 1'b1; step(5);
    wr(4'd7, 32'h8);
    rd(4'd7, v); chk("R6 level flag not clearable", v, 32'h8);
    lines[3] = 1'b0; step(4);
    wr(4'd7, 32'h8);
    rd(4'd7, v); chk("R6 clears after level leaves", v, 0);
    wr(4'd8, 0); step(2);

    // R8 events
    wr(4'd4, 32'h10);
    wr(4'd8, 32'h0011_0000);
    lines[4] = 1'b1; lines[5] = 1'b1;
    step(3);
    chk("R8 event pulse masked", 32'(evt), 32'h10);
    step(1);
    chk("R8 event lasts one cycle", 32'(evt), 0);
    lines = '0; wr(4'd8, 0); wr(4'd4, 0); step(6); wr(4'd7, 32'hFFFF);

    // R9 non-maskable with filter bypass
    wr(4'd2, 32'h19);
    nmi = 1'b1; step(1); nmi = 1'b0; step(6);
    chk("R9 bypass catches glitch", 32'(nmio), 1);
    wr(4'd3, 32'h1);
    chk("R9 flag cleared", 32'(nmio), 0);
    wr(4'd2, 32'h09);
    nmi = 1'b1; step(1); nmi = 1'b0; step(6);
    chk("R9 filter rejects glitch", 32'(nmio), 0);
    wr(4'd2, 0);

    // R12 pin state
    lines = 16'h00A5; step(5);
    rd(4'd10, v); chk("R12 pin state", v, 32'h00A5);
    lines = '0; step(5); wr(4'd7, 32'hFFFF);

    // R10 disabled controller
    wr(4'd0, 32'h0); step(2);
    wr(4'd4, 32'h1); wr(4'd8, 32'h1);
    lines[0] = 1'b1; step(3);
    chk("R10 no event when off", 32'(evt), 0);
    step(3);
    rd(4'd7, v); chk("R10 no flag when off", v, 0);
    lines = '0; step(4);

    // R11 software reset
    wr(4'd6, 32'hFF);
    wr(4'd0, 32'h3);
    rd(4'd1, v); chk("R11 busy both bits", v, 32'h3);
    step(2);
    rd(4'd6, v); chk("R11 enables cleared", v, 0);
    rd(4'd8, v); chk("R11 cfg cleared", v, 0);
    rd(4'd4, v); chk("R11 mask cleared", v, 0);
    rd(4'd0, v); chk("R11 controller off", v, 0);

    finish_run();
  end
endmodule